// File: doc/BRIEF.md
# Runahead Branch Resolution Policy Unit

This unit resolves conditional branches, direct jumps, indirect jumps and subroutine returns while the core pre-executes past a cache miss, and also in normal operation. In normal mode the computed branch result is passed straight through. In runahead mode each operand may be marked poisoned. When that happens the unit picks the outcome from a policy select. The aggressive setting falls back to the supplied branch prediction or the supplied return-stack top. The conservative setting raises a stall, which holds until runahead mode ends.

Each accepted branch yields one registered result: a direction and a next fetch address. Conditional outcomes that runahead computes from clean operands are written to a small replay log of PC and direction pairs. Normal-mode logic drains that log later with a pop strobe. The predictor and the return stack lie outside the block and arrive as inputs.

Top module: `ra_branch_resolver`

## Requirements
- R1: After reset, res_valid_o, stall_o and rec_valid_o are all 0.
- R2: With runahead_i = 0, an accepted branch is resolved from its computed values and the validity flags are ignored. A conditional branch (br_kind_i = 0) gives res_taken_o = cond_taken_i. An indirect jump (2) or a return (3) is taken to br_tgt_i. stall_o stays 0 and nothing is logged. A not-taken next PC is br_pc_i + INSN_BYTES.
- R3: In runahead, a conditional branch with cond_ok_i = 1 uses cond_taken_i (next PC br_tgt_i when taken) and appends {br_pc_i, direction} to the replay log.
- R4: In runahead under the aggressive policy (policy_aggr_i = 1), a conditional branch with cond_ok_i = 0 takes its direction from pred_taken_i. It is not logged.
- R5: In runahead under the conservative policy (policy_aggr_i = 0), a conditional branch with cond_ok_i = 0 raises a stall, and so does a return with tgt_ok_i = 0. A stalling branch reports res_taken_o = 0 and res_npc_o = br_pc_i.
- R6: In runahead, an indirect jump with tgt_ok_i = 0 raises a stall under either policy. With tgt_ok_i = 1 it is taken to br_tgt_i.
- R7: In runahead, a return with tgt_ok_i = 1 goes to br_tgt_i. Under the aggressive policy with tgt_ok_i = 0 it is taken to ras_top_i.
- R8: Once stall_o is 1, it stays 1 while runahead_i stays 1, and it reads 0 one cycle after runahead_i goes to 0. Branches offered while stall_o is 1 give no result and no log entry.
- R9: The replay log returns entries oldest first, and rec_pop_i removes the head. A push into a full log (LOG_DEPTH entries) is dropped. A pop on an empty log has no effect.
- R10: A direct jump (br_kind_i = 1) is always taken to br_tgt_i, in either mode and under either policy, and is never logged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| runahead_i | input | 1 | 1 while the core is in runahead mode |
| policy_aggr_i | input | 1 | 1 = aggressive policy, 0 = conservative policy |
| br_valid_i | input | 1 | A branch is offered this cycle |
| br_kind_i | input | 2 | 0 conditional, 1 direct jump, 2 indirect jump, 3 return |
| br_pc_i | input | PC_W | PC of the branch |
| cond_ok_i | input | 1 | Condition operands are valid |
| cond_taken_i | input | 1 | Computed condition outcome |
| br_tgt_i | input | PC_W | Computed target address |
| tgt_ok_i | input | 1 | Target register is valid |
| pred_taken_i | input | 1 | Predicted direction |
| ras_top_i | input | PC_W | Top entry of the return stack |
| res_valid_o | output | 1 | Result strobe, one cycle after acceptance |
| res_taken_o | output | 1 | Resolved direction |
| res_npc_o | output | PC_W | Resolved next fetch address |
| stall_o | output | 1 | Stall request |
| rec_pop_i | input | 1 | Remove the head of the replay log |
| rec_valid_o | output | 1 | Replay log holds at least one entry |
| rec_pc_o | output | PC_W | PC of the log head |
| rec_taken_o | output | 1 | Direction of the log head |

## Verification
A branch that is accepted on one rising edge shows its result on the outputs for the following cycle only. So the bench drives each branch on a falling edge, and a monitor compares against a queue of expected results on the next falling edge. Any extra result, or one that never comes, counts as an error. A stall shows up on the falling edge after the branch that caused it, and it clears on the falling edge after runahead_i falls. A new log entry, or the effect of a pop, appears one edge after the strobe. Every direct check samples on a falling edge, halfway between the register updates.

// File: rtl/ra_br_pkg.sv
package ra_br_pkg;

   typedef enum logic [1:0] {
      BK_COND  = 2'd0,
      BK_JUMP  = 2'd1,
      BK_INDIR = 2'd2,
      BK_RET   = 2'd3
   } br_kind_e;

endpackage

// File: rtl/ra_br_decide.sv
module ra_br_decide #(
   parameter int PC_W       = 32,
   parameter int INSN_BYTES = 4
) (
   input  logic                 run_i,
   input  logic                 aggr_i,
   input  ra_br_pkg::br_kind_e  kind_i,
   input  logic [PC_W-1:0]      pc_i,
   input  logic                 cond_ok_i,
   input  logic                 cond_taken_i,
   input  logic [PC_W-1:0]      tgt_i,
   input  logic                 tgt_ok_i,
   input  logic                 pred_i,
   input  logic [PC_W-1:0]      ras_i,
   output logic                 taken_o,
   output logic [PC_W-1:0]      npc_o,
   output logic                 stall_o,
   output logic                 log_o
);
   localparam logic [PC_W-1:0] STEP_V = PC_W'(INSN_BYTES);

   logic [PC_W-1:0] seq_pc;
   logic            use_ras;

   assign seq_pc = pc_i + STEP_V;

   always_comb begin
      taken_o = 1'b0;
      stall_o = 1'b0;
      log_o   = 1'b0;
      use_ras = 1'b0;
      unique case (kind_i)
         ra_br_pkg::BK_COND: begin
            if (!run_i || cond_ok_i) begin
               taken_o = cond_taken_i;
               log_o   = run_i;
            end else if (aggr_i) begin
               taken_o = pred_i;
            end else begin
               stall_o = 1'b1;
            end
         end
         ra_br_pkg::BK_JUMP: taken_o = 1'b1;
         ra_br_pkg::BK_INDIR: begin
            if (!run_i || tgt_ok_i) taken_o = 1'b1;
            else                    stall_o = 1'b1;
         end
         ra_br_pkg::BK_RET: begin
            if (!run_i || tgt_ok_i) begin
               taken_o = 1'b1;
            end else if (aggr_i) begin
               taken_o = 1'b1;
               use_ras = 1'b1;
            end else begin
               stall_o = 1'b1;
            end
         end
         default: taken_o = 1'b0;
      endcase

      if (stall_o)      npc_o = pc_i;
      else if (use_ras) npc_o = ras_i;
      else if (taken_o) npc_o = tgt_i;
      else              npc_o = seq_pc;
   end

endmodule

// File: rtl/ra_br_log.sv
module ra_br_log #(
   parameter int DEPTH = 4,
   parameter int W     = 33
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         push_i,
   input  logic [W-1:0] din_i,
   input  logic         pop_i,
   output logic         valid_o,
   output logic [W-1:0] dout_o
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL_V = CNT_W'(DEPTH);

   logic [CNT_W-1:0] count_q;
   logic             accept;
   logic             take;

   assign accept  = push_i && (count_q != FULL_V);
   assign take    = pop_i && (count_q != '0);
   assign valid_o = (count_q != '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         count_q <= '0;
      end else begin
         case ({accept, take})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot_q;
         always_ff @(posedge clk_i) begin
            if (accept) slot_q <= din_i;
         end
         assign dout_o = slot_q;
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         localparam logic [PTR_W-1:0] LAST_V = PTR_W'(DEPTH - 1);
         logic [W-1:0]     mem_q [DEPTH];
         logic [PTR_W-1:0] wr_q;
         logic [PTR_W-1:0] rd_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               wr_q <= '0;
               rd_q <= '0;
            end else begin
               if (accept) wr_q <= (wr_q == LAST_V) ? '0 : wr_q + 1'b1;
               if (take)   rd_q <= (rd_q == LAST_V) ? '0 : rd_q + 1'b1;
            end
         end

         always_ff @(posedge clk_i) begin
            if (accept) mem_q[wr_q] <= din_i;
         end

         assign dout_o = mem_q[rd_q];
      end
   endgenerate

endmodule

// File: rtl/ra_branch_resolver.sv
module ra_branch_resolver #(
   parameter int PC_W       = 32,
   parameter int LOG_DEPTH  = 4,
   parameter int INSN_BYTES = 4
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            runahead_i,
   input  logic            policy_aggr_i,
   input  logic            br_valid_i,
   input  logic [1:0]      br_kind_i,
   input  logic [PC_W-1:0] br_pc_i,
   input  logic            cond_ok_i,
   input  logic            cond_taken_i,
   input  logic [PC_W-1:0] br_tgt_i,
   input  logic            tgt_ok_i,
   input  logic            pred_taken_i,
   input  logic [PC_W-1:0] ras_top_i,
   output logic            res_valid_o,
   output logic            res_taken_o,
   output logic [PC_W-1:0] res_npc_o,
   output logic            stall_o,
   input  logic            rec_pop_i,
   output logic            rec_valid_o,
   output logic [PC_W-1:0] rec_pc_o,
   output logic            rec_taken_o
);
   localparam int REC_W = PC_W + 1;

   generate
      if (PC_W < 8)        begin : g_bad_pc    $error("PC_W must be at least 8"); end
      if (LOG_DEPTH < 1)   begin : g_bad_depth $error("LOG_DEPTH must be at least 1"); end
      if (INSN_BYTES < 1)  begin : g_bad_step  $error("INSN_BYTES must be at least 1"); end
   endgenerate

   logic            d_taken;
   logic [PC_W-1:0] d_npc;
   logic            d_stall;
   logic            d_log;
   logic            accept;
   logic            stall_q;
   logic            rv_q;
   logic            rt_q;
   logic [PC_W-1:0] rn_q;
   logic [REC_W-1:0] rec_word;

   assign accept = br_valid_i && !stall_q;

   ra_br_decide #(
      .PC_W       (PC_W),
      .INSN_BYTES (INSN_BYTES)
   ) u_decide (
      .run_i        (runahead_i),
      .aggr_i       (policy_aggr_i),
      .kind_i       (ra_br_pkg::br_kind_e'(br_kind_i)),
      .pc_i         (br_pc_i),
      .cond_ok_i    (cond_ok_i),
      .cond_taken_i (cond_taken_i),
      .tgt_i        (br_tgt_i),
      .tgt_ok_i     (tgt_ok_i),
      .pred_i       (pred_taken_i),
      .ras_i        (ras_top_i),
      .taken_o      (d_taken),
      .npc_o        (d_npc),
      .stall_o      (d_stall),
      .log_o        (d_log)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stall_q <= 1'b0;
         rv_q    <= 1'b0;
         rt_q    <= 1'b0;
         rn_q    <= '0;
      end else begin
         stall_q <= runahead_i && (stall_q || (accept && d_stall));
         rv_q    <= accept;
         if (accept) begin
            rt_q <= d_taken;
            rn_q <= d_npc;
         end
      end
   end

   ra_br_log #(
      .DEPTH (LOG_DEPTH),
      .W     (REC_W)
   ) u_log (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (accept && d_log),
      .din_i   ({br_pc_i, d_taken}),
      .pop_i   (rec_pop_i),
      .valid_o (rec_valid_o),
      .dout_o  (rec_word)
   );

   assign rec_pc_o    = rec_word[REC_W-1:1];
   assign rec_taken_o = rec_word[0];
   assign res_valid_o = rv_q;
   assign res_taken_o = rt_q;
   assign res_npc_o   = rn_q;
   assign stall_o     = stall_q;

endmodule

// File: rtl/ra_br_checker.sv
module ra_br_checker #(
   parameter int PC_W = 32
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            runahead_i,
   input logic            policy_aggr_i,
   input logic            br_valid_i,
   input logic [1:0]      br_kind_i,
   input logic            cond_ok_i,
   input logic            cond_taken_i,
   input logic [PC_W-1:0] br_tgt_i,
   input logic            tgt_ok_i,
   input logic            pred_taken_i,
   input logic [PC_W-1:0] ras_top_i,
   input logic            res_valid_o,
   input logic            res_taken_o,
   input logic [PC_W-1:0] res_npc_o,
   input logic            stall_o
);
   logic taken_in;
   assign taken_in = br_valid_i && !stall_o;

   a_r8_no_stall_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !runahead_i |=> !stall_o);

   a_r8_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stall_o && runahead_i) |=> stall_o);

   a_r8_no_result_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_o |=> !res_valid_o);

   a_r2_normal_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (taken_in && !runahead_i && br_kind_i == 2'd0)
      |=> (res_valid_o && res_taken_o == $past(cond_taken_i)));

   a_r4_predicted: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (taken_in && runahead_i && policy_aggr_i && br_kind_i == 2'd0 && !cond_ok_i)
      |=> (res_valid_o && res_taken_o == $past(pred_taken_i)));

   a_r6_indir_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (taken_in && runahead_i && br_kind_i == 2'd2 && !tgt_ok_i) |=> stall_o);

   a_r7_ret_stack: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (taken_in && runahead_i && policy_aggr_i && br_kind_i == 2'd3 && !tgt_ok_i)
      |=> (res_taken_o && res_npc_o == $past(ras_top_i)));

   a_r10_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (taken_in && br_kind_i == 2'd1)
      |=> (res_taken_o && res_npc_o == $past(br_tgt_i)));

endmodule

bind ra_branch_resolver ra_br_checker #(.PC_W(PC_W)) u_chk (.*);

// File: tb/tb_ra_branch_resolver.sv
`timescale 1ns/1ps
module tb_ra_branch_resolver;
   localparam int PC_W  = 32;
   localparam int DEPTH = 4;

   typedef struct {
      logic        taken;
      logic [31:0] npc;
      string       tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic runahead = 1'b0, aggr = 1'b0, bv = 1'b0;
   logic [1:0] kind = 2'd0;
   logic [31:0] pc = '0, tgt = '0, ras = '0;
   logic cok = 1'b0, ctk = 1'b0, tok = 1'b0, pred = 1'b0, pop = 1'b0;
   logic res_v, res_t, stall, rec_v, rec_t;
   logic [31:0] res_n, rec_pc;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   ra_branch_resolver #(.PC_W(PC_W), .LOG_DEPTH(DEPTH), .INSN_BYTES(4)) dut (
      .clk_i(clk), .rst_ni(rst_n), .runahead_i(runahead), .policy_aggr_i(aggr),
      .br_valid_i(bv), .br_kind_i(kind), .br_pc_i(pc), .cond_ok_i(cok),
      .cond_taken_i(ctk), .br_tgt_i(tgt), .tgt_ok_i(tok), .pred_taken_i(pred),
      .ras_top_i(ras), .res_valid_o(res_v), .res_taken_o(res_t), .res_npc_o(res_n),
      .stall_o(stall), .rec_pop_i(pop), .rec_valid_o(rec_v), .rec_pc_o(rec_pc),
      .rec_taken_o(rec_t));

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   // monitor: every result is compared against the oldest expected item
   always @(negedge clk) begin
      if (rst_n && res_v) begin
         if (sb.size() == 0) begin
            chk("R8", "unexpected result", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, "taken", res_t, e.taken);
            chk(e.tag, "npc", res_n, e.npc);
         end
      end
   end

   task automatic br(input logic [1:0] k, input logic [31:0] p, input logic c_ok,
                     input logic c_tk, input logic [31:0] t, input logic t_ok,
                     input logic pr, input logic [31:0] rs, input logic ev,
                     input logic et, input logic [31:0] en, input string tag);
      exp_t e;
      @(negedge clk);
      kind = k; pc = p; cok = c_ok; ctk = c_tk; tgt = t; tok = t_ok;
      pred = pr; ras = rs; bv = 1'b1;
      if (ev) begin
         e.taken = et; e.npc = en; e.tag = tag;
         sb.push_back(e);
      end
      @(negedge clk);
      bv = 1'b0;
   endtask

   task automatic mode(input logic run, input logic ag);
      @(negedge clk);
      runahead = run; aggr = ag;
      @(negedge clk);
   endtask

   task automatic pop_one;
      @(negedge clk);
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
   endtask

   task automatic head(input string tag, input logic v, input logic [31:0] p,
                       input logic t);
      chk(tag, "rec_valid", rec_v, v);
      if (v) begin
         chk(tag, "rec_pc", rec_pc, p);
         chk(tag, "rec_taken", rec_t, t);
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "res_valid", res_v, 0);
      chk("R1", "stall", stall, 0);
      chk("R1", "rec_valid", rec_v, 0);
      rst_n = 1'b1;

      // normal mode: computed values pass, validity ignored
      br(2'd0, 32'h100, 1, 1, 32'h200, 1, 0, 0, 1, 1, 32'h200, "R2");
      br(2'd0, 32'h104, 0, 0, 32'h250, 0, 1, 0, 1, 0, 32'h108, "R2");
      br(2'd2, 32'h108, 0, 0, 32'h300, 0, 0, 0, 1, 1, 32'h300, "R2");
      chk("R2", "stall in normal", stall, 0);
      br(2'd3, 32'h10c, 0, 0, 32'h340, 0, 0, 32'h999, 1, 1, 32'h340, "R2");
      br(2'd1, 32'h110, 0, 0, 32'h400, 0, 0, 0, 1, 1, 32'h400, "R10");
      chk("R2", "nothing logged in normal", rec_v, 0);

      // runahead, aggressive
      mode(1, 1);
      br(2'd0, 32'h500, 1, 1, 32'h600, 0, 0, 0, 1, 1, 32'h600, "R3");
      br(2'd0, 32'h504, 1, 0, 32'h600, 0, 1, 0, 1, 0, 32'h508, "R3");
      br(2'd0, 32'h508, 0, 0, 32'h700, 0, 1, 0, 1, 1, 32'h700, "R4");
      br(2'd0, 32'h50c, 0, 1, 32'h710, 0, 0, 0, 1, 0, 32'h510, "R4");
      br(2'd3, 32'h510, 0, 0, 32'h900, 0, 0, 32'h800, 1, 1, 32'h800, "R7");
      br(2'd3, 32'h514, 0, 0, 32'h904, 1, 0, 32'h800, 1, 1, 32'h904, "R7");
      br(2'd1, 32'h518, 0, 0, 32'ha00, 0, 0, 0, 1, 1, 32'ha00, "R10");
      head("R3", 1, 32'h500, 1);
      pop_one();
      head("R3", 1, 32'h504, 0);
      pop_one();
      head("R4", 0, 0, 0);
      pop_one();
      head("R9", 0, 0, 0);
      br(2'd0, 32'h520, 1, 1, 32'h620, 0, 0, 0, 1, 1, 32'h620, "R3");
      head("R9", 1, 32'h520, 1);
      pop_one();
      head("R9", 0, 0, 0);

      // indirect jump with poisoned target stalls even when aggressive
      br(2'd2, 32'h530, 0, 0, 32'hb00, 0, 0, 0, 1, 0, 32'h530, "R6");
      chk("R6", "stall", stall, 1);
      br(2'd0, 32'h540, 1, 1, 32'hb40, 0, 0, 0, 0, 0, 0, "R8");
      chk("R8", "stall held", stall, 1);
      chk("R8", "no log while stalled", rec_v, 0);
      mode(0, 1);
      chk("R8", "stall cleared", stall, 0);

      // conservative policy
      mode(1, 0);
      br(2'd0, 32'h600, 0, 0, 32'hc00, 0, 1, 0, 1, 0, 32'h600, "R5");
      chk("R5", "stall cond", stall, 1);
      mode(0, 0);
      chk("R8", "stall cleared", stall, 0);
      mode(1, 0);
      br(2'd3, 32'h610, 0, 0, 32'hc40, 0, 0, 32'h800, 1, 0, 32'h610, "R5");
      chk("R5", "stall ret", stall, 1);
      mode(0, 0);
      mode(1, 0);
      br(2'd2, 32'h620, 0, 0, 32'hb00, 1, 0, 0, 1, 1, 32'hb00, "R6");
      chk("R6", "no stall valid target", stall, 0);
      br(2'd1, 32'h624, 0, 0, 32'hd00, 0, 0, 0, 1, 1, 32'hd00, "R10");

      // fill the log past its depth
      for (int i = 0; i < DEPTH + 1; i++) begin
         logic tk;
         logic [31:0] p;
         tk = (i % 2 == 0);
         p  = 32'h700 + 32'(i * 4);
         br(2'd0, p, 1, tk, 32'he00, 0, 0, 0, 1, tk, tk ? 32'he00 : p + 32'd4, "R3");
      end
      for (int i = 0; i < DEPTH; i++) begin
         head("R9", 1, 32'h700 + 32'(i * 4), (i % 2 == 0));
         pop_one();
      end
      head("R9", 0, 0, 0);
      mode(0, 0);
      br(2'd0, 32'h800, 0, 1, 32'h880, 0, 0, 0, 1, 1, 32'h880, "R2");
      chk("R2", "stall back in normal", stall, 0);

      repeat (3) @(negedge clk);
      while (sb.size() != 0) begin
         exp_t e;
         e = sb.pop_front();
         chk(e.tag, "missing result", 0, 1);
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule